// File: doc/BRIEF.md
# Linear Frequency Sweep Tuning-Word Generator

This block supplies the frequency tuning word for a direct digital synthesizer that sweeps linearly. Software loads three values through a small write port: a base tuning word, a signed increment, and a pacing count. A divide-by-eight prescaler drives a countdown that is reloaded from the pacing count. Each time the countdown expires, the increment, doubled, is added into a sweep accumulator. The tuning word leaves the block as the base word plus the accumulator, taken modulo 2^32.

The sweep has no endpoint of its own. It runs until software writes a pacing count of zero, and the output then holds where it is. The base word is never modified by sweeping. An autoclear input empties the accumulator, which returns the output to the base frequency. A sleep input freezes the prescaler, the countdown and the accumulator, and sweeping resumes from exactly where it stopped.

Top module: `sweep_ftw_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears, so `ftw_out` reads 0 after the edge.
- R2: Let P be a nonzero pacing count written at edge E0. The first increment lands at edge E0+8·P, and further increments follow every 8·P edges.
- R3: When the pacing count is 0, no increment is ever applied and `ftw_out` holds its value, however long the wait.
- R4: Each increment adds the step word shifted left by one bit, with bit 31 of the step dropped. The step is two's complement, so a negative step sweeps downward. `ftw_out` equals base plus accumulator, taken modulo 2^32.
- R5: Sweeping never changes the base word. A write of a new base moves `ftw_out` to the new base plus the current accumulator at the next edge.
- R6: When `autoclear` is high at an edge and `sleep` is low, the accumulator becomes 0, so `ftw_out` equals the base. This takes priority over an increment due on the same edge, and the pacing continues on its normal schedule.
- R7: While `sleep` is high, the prescaler, countdown and accumulator hold, and `autoclear` has no effect. After `sleep` falls, the pending interval completes with only its remaining cycles.
- R8: A write with `wr_en` high takes effect at the next edge. Select 0 writes the base word. Select 1 writes the step word. Select 2 writes the pacing count from `wr_data[15:0]`. Select 3 changes nothing.
- R9: A write of the pacing count restarts both the prescaler and the countdown, so the next increment comes a full 8·P edges after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Freezes prescaler, countdown and accumulator |
| autoclear | input | 1 | Empties the sweep accumulator |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 base, 1 step, 2 pacing, 3 unused |
| wr_data | input | 32 | Write data |
| ftw_out | output | 32 | Base word plus sweep accumulator |

## Verification
Two cases are hardest to reach from the ports. The first is an autoclear that lands on the very edge an increment is due. The second is a sleep that starts in the middle of a prescaler interval. Neither can be seen directly, because the prescaler phase and the countdown are internal. The bench therefore rewrites the pacing count, which restarts both from a known point. It then counts edges exactly from that write before it raises `autoclear` or `sleep`. A table of sweeps covers wrap-around, a negative step and a step with bit 30 set. It also includes the edge just before the first increment.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    parameter int TW_W   = 32;   // tuning word width
    parameter int RATE_W = 16;   // pacing count width
    parameter int PRE_W  = 3;    // prescaler bits, divide by 2**PRE_W

    localparam int PRE_LAST = (1 << PRE_W) - 1;

    typedef logic [TW_W-1:0]   tw_t;
    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [PRE_W-1:0]  pre_t;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_DELTA = 2'd1,
        SEL_PACE  = 2'd2,
        SEL_SPARE = 2'd3
    } sel_e;

    typedef struct packed {
        tw_t   base;
        tw_t   delta;
        rate_t pace;
    } cfg_t;

    // One step LSB weighs two tuning-word LSBs.
    function automatic tw_t delta_to_inc(tw_t d);
        return {d[TW_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
    import sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  tw_t        wr_data,
    output cfg_t       cfg,
    output logic       pace_load,
    output rate_t      pace_wdata
);

    sel_e sel;
    assign sel        = sel_e'(wr_sel);
    assign pace_load  = wr_en && (sel == SEL_PACE);
    assign pace_wdata = wr_data[RATE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_BASE:  cfg.base  <= wr_data;
                SEL_DELTA: cfg.delta <= wr_data;
                SEL_PACE:  cfg.pace  <= pace_wdata;
                SEL_SPARE: ;
            endcase
        end
    end

    AST_BASE_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_BASE) |=> $stable(cfg.base)); // R5

    AST_PACE_WRITE: assert property (@(posedge clk) disable iff (rst)
        pace_load |=> cfg.pace == $past(pace_wdata)); // R8

    AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SPARE) |=> $stable(cfg)); // R8

endmodule

// File: rtl/sweep_pacer.sv
module sweep_pacer
    import sweep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep,
    input  rate_t pace,
    input  logic  pace_load,
    input  rate_t pace_wdata,
    output logic  fire
);

    pre_t  pre_cnt;
    rate_t down_cnt;
    logic  tick;
    logic  expiring;

    assign tick     = (pre_cnt == pre_t'(PRE_LAST)) && !sleep;
    assign expiring = (down_cnt <= rate_t'(1));
    assign fire     = tick && !pace_load && (pace != '0) && expiring;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (pace_load) begin
            pre_cnt <= '0;
        end else if (!sleep) begin
            pre_cnt <= pre_cnt + pre_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            down_cnt <= '0;
        end else if (pace_load) begin
            down_cnt <= pace_wdata;
        end else if (tick && pace != '0) begin
            if (expiring) down_cnt <= pace;
            else          down_cnt <= down_cnt - rate_t'(1);
        end
    end

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sleep && !pace_load) |=> ($stable(pre_cnt) && $stable(down_cnt))); // R7

    AST_HALT_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        (pace == '0) |-> !fire); // R3

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        pace_load |=> (pre_cnt == '0 && down_cnt == $past(pace_wdata))); // R9

    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        fire |-> (pre_cnt == pre_t'(PRE_LAST) && !sleep)); // R2

endmodule

// File: rtl/sweep_accum.sv
module sweep_accum
    import sweep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic clear,
    input  logic step,
    input  tw_t  inc,
    output tw_t  acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (!hold) begin
            if (clear)     acc <= '0;
            else if (step) acc <= acc + inc;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(acc)); // R7

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (clear && !hold) |=> acc == '0); // R6

    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !hold) |=> acc == $past(acc) + $past(inc)); // R4

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(acc)); // R3

endmodule

// File: rtl/sweep_ftw_gen.sv
module sweep_ftw_gen
    import sweep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sleep,
    input  logic        autoclear,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ftw_out
);

    cfg_t  cfg;
    logic  pace_load;
    rate_t pace_wdata;
    logic  fire;
    tw_t   acc;
    tw_t   inc;

    sweep_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (tw_t'(wr_data)),
        .cfg        (cfg),
        .pace_load  (pace_load),
        .pace_wdata (pace_wdata)
    );

    sweep_pacer u_pacer (
        .clk        (clk),
        .rst        (rst),
        .sleep      (sleep),
        .pace       (cfg.pace),
        .pace_load  (pace_load),
        .pace_wdata (pace_wdata),
        .fire       (fire)
    );

    assign inc = delta_to_inc(cfg.delta);

    sweep_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .hold  (sleep),
        .clear (autoclear),
        .step  (fire),
        .inc   (inc),
        .acc   (acc)
    );

    assign ftw_out = 32'(cfg.base + acc);

    AST_OUT_RESET: assert property (@(posedge clk)
        rst |=> ftw_out == '0); // R1

endmodule

// File: tb/sweep_ftw_gen_test.sv
module sweep_ftw_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep = 1'b0;
    logic        autoclear = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] ftw_out;

    int checks = 0;
    int errors = 0;

    sweep_ftw_gen uut (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .autoclear (autoclear),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ftw_out   (ftw_out)
    );

    always #5 clk = ~clk;

    // {base, step, pace, edges after pace write, expected word}
    localparam logic [127:0] VEC [7] = '{
        {32'h0000_1000, 32'h0000_0005, 16'd1, 16'd40, 32'h0000_1032},
        {32'h0000_1000, 32'hFFFF_FFFD, 16'd2, 16'd50, 32'h0000_0FEE},
        {32'hFFFF_FFF0, 32'h0000_0010, 16'd1, 16'd16, 32'h0000_0030},
        {32'h0000_0010, 32'h4000_0000, 16'd1, 16'd8,  32'h8000_0010},
        {32'h1234_5678, 32'h0000_0007, 16'd0, 16'd100, 32'h1234_5678},
        {32'h0000_0000, 32'h0000_0001, 16'd3, 16'd23, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0001, 16'd3, 16'd24, 32'h0000_0002}
    };

    task automatic step_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_edges(2);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset", ftw_out, 32'h0);

        // Table of sweeps: R2 cadence, R4 signed/doubled/wrapping, R3 halt
        for (int i = 0; i < 7; i++) begin
            logic [127:0] v;
            v = VEC[i];
            do_reset();
            wr(2'd0, v[127:96]);
            wr(2'd1, v[95:64]);
            wr(2'd2, {16'h0, v[63:48]});
            step_edges(int'(v[47:32]));
            check("R2 R4 sweep table", ftw_out, v[31:0]);
        end

        // R3: halting holds the output; R5: base rewrite
        do_reset();
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd1);
        step_edges(16);
        check("R2 two steps", ftw_out, 32'd4);
        wr(2'd2, 32'd0);
        step_edges(40);
        check("R3 halt holds", ftw_out, 32'd4);
        wr(2'd0, 32'h0000_1000);
        check("R5 new base plus accumulator", ftw_out, 32'h0000_1004);

        // R6: autoclear on the edge an increment is due
        do_reset();
        wr(2'd0, 32'h100);
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd1);
        step_edges(16);
        check("R6 before clear", ftw_out, 32'h104);
        step_edges(7);
        autoclear = 1'b1;
        step_edges(1);
        autoclear = 1'b0;
        check("R6 clear wins over step", ftw_out, 32'h100);
        step_edges(8);
        check("R6 cadence continues", ftw_out, 32'h102);

        // R7: sleep mid-interval
        do_reset();
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd1);
        step_edges(4);
        sleep = 1'b1;
        step_edges(20);
        sleep = 1'b0;
        step_edges(3);
        check("R7 remaining interval not done", ftw_out, 32'd0);
        step_edges(1);
        check("R7 step after resume", ftw_out, 32'd2);
        sleep = 1'b1;
        autoclear = 1'b1;
        step_edges(3);
        check("R7 autoclear ignored in sleep", ftw_out, 32'd2);
        sleep = 1'b0;
        autoclear = 1'b0;

        // R8: spare select ignored, pacing uses low 16 bits
        do_reset();
        wr(2'd1, 32'd1);
        wr(2'd3, 32'h0000_0001);
        step_edges(20);
        check("R8 select 3 ignored", ftw_out, 32'd0);
        wr(2'd2, 32'h0001_0001);
        step_edges(8);
        check("R8 pacing low bits", ftw_out, 32'd2);

        // R9: rewriting pacing restarts the interval
        do_reset();
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd1);
        step_edges(5);
        wr(2'd2, 32'd1);
        step_edges(7);
        check("R9 restart no early step", ftw_out, 32'd0);
        step_edges(1);
        check("R9 full interval step", ftw_out, 32'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule